// File: doc/BRIEF.md
# Memory Array Supply Mux Sequencer

This block moves the supply of on-chip memory arrays between two power rails: the general logic rail and a rail dedicated to the memories. Software asks for a rail by writing a mode register. When the request names the other rail, a state machine carries out a break-before-make switch. It first stops the array clock. It then opens the head switch of the rail in use and closes the head switch of the new rail. Last, it lets the clock run again. A status register shows which step is in progress and, at the end, which rail the arrays have settled on.

A single packed delay word sets the length of each of the four waiting phases. The phases are the halt settle, the post-halt wait, the open-switch gap and the resume wait. Software can retune each phase on its own by a read-modify-write of its byte. A request that arrives while a switch is running is held. It starts only once the running switch has reported its done code. A request for the rail that is already selected does nothing.

Top module: `arraymux_seq`

## Requirements
- R1: After reset, hs_logic_en is 1, hs_mem_en is 0 and clk_halt is 0. The status register (address 1) reads 0x3, the mode register (address 0) reads 0x02, and both the delay register (address 2) and the unused address 3 read 0.
- R2: A mode write of 0x00 requests the memory rail and a write of 0x02 requests the logic rail. Any other value is ignored: no switch starts and the mode readback keeps its previous value.
- R3: Only bits 3:0 of the status register carry information, and bits 31:4 read 0. The status reads 0x0 when the arrays are settled on the memory rail and 0x3 when they are settled on the logic rail.
- R4: A switch steps through these phases in this order. First clk_halt rises and the status reads 0x1 (halt settle). Next the status reads 0x2 (post-halt wait). Next both head-switch enables are 0 and the status reads 0x4. Next only the new rail's enable is 1 and the status reads 0x5. Last, clk_halt falls and the done code appears.
- R5: A phase whose delay field holds n lasts n+1 clock cycles, so a field of 0 gives one cycle. The old enable stays on for (halt+post+2) of the halted cycles. Both enables are off for (sel+1) cycles. The new enable is on for (resume+1) halted cycles.
- R6: The delay register reads back exactly what was written. Its fields are: bits 7:0 open-switch gap, bits 15:8 resume wait, bits 23:16 halt settle, bits 31:24 post-halt wait.
- R7: A write that requests the rail already selected causes no clock halt, and the status does not change.
- R8: A valid mode write during a running switch is held, and only the latest one is kept. Once the switch ends, clk_halt stays low for exactly one cycle before the held request starts. A held request for the rail just reached starts nothing.
- R9: hs_logic_en and hs_mem_en are never 1 in the same cycle. While the clock is not halted, exactly one of them is 1.
- R10: A head-switch enable changes only while clk_halt is 1 both in that cycle and in the cycle before it.
- R11: With every field at its maximum (0xFF), a switch holds clk_halt for 1024 cycles. At 200 MHz that is 5.12 us, inside a 10 us software timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 mode, 1 status (read-only), 2 delay |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe; data returns one cycle later |
| rd_addr | input | 2 | Read address |
| rd_data | output | 32 | Registered read data |
| hs_logic_en | output | 1 | Head-switch enable tying the arrays to the logic rail |
| hs_mem_en | output | 1 | Head-switch enable tying the arrays to the memory rail |
| clk_halt | output | 1 | Stops the array clock while high |

## Verification
The checker watches every cycle for the following: the two enables never overlap, exactly one enable is on while the clock runs, an enable never moves unless the clock has been halted for at least one full cycle, and the status shows a done code exactly when the clock is running, with that code matching the enabled rail. Only the bench scenarios can show the cycle count of each phase against the four delay fields, the order of the status codes, the one-cycle gap before a held request starts, the rule that the latest held request wins, and that both same-rail writes and unknown mode values have no effect.

// File: rtl/arraymux_pkg.sv
package arraymux_pkg;

  localparam int NUM_PHASES = 4;

  // byte index of each phase inside the packed delay word
  localparam int PH_SEL  = 0;
  localparam int PH_RES  = 1;
  localparam int PH_HALT = 2;
  localparam int PH_POST = 3;

  // register word addresses
  localparam int ADR_MODE   = 0;
  localparam int ADR_STATUS = 1;
  localparam int ADR_DELAY  = 2;

  localparam logic [3:0] STS_MEM_DONE   = 4'h0;
  localparam logic [3:0] STS_HALTING    = 4'h1;
  localparam logic [3:0] STS_POSTHALT   = 4'h2;
  localparam logic [3:0] STS_LOGIC_DONE = 4'h3;
  localparam logic [3:0] STS_OPEN       = 4'h4;
  localparam logic [3:0] STS_RESUME     = 4'h5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HALT,
    ST_POST,
    ST_SEL,
    ST_RES
  } seq_state_t;

endpackage

// File: rtl/arraymux_regs.sv
module arraymux_regs
  import arraymux_pkg::*;
#(
  parameter int              DATA_W     = 32,
  parameter int              ADDR_W     = 2,
  parameter int              FIELD_W    = 8,
  parameter logic [DATA_W-1:0] MODE_MEM   = 'h00,
  parameter logic [DATA_W-1:0] MODE_LOGIC = 'h02,
  parameter logic [DATA_W-1:0] DLY_RST    = '0
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                wr_en,
  input  logic [ADDR_W-1:0]                   wr_addr,
  input  logic [DATA_W-1:0]                   wr_data,
  input  logic                                rd_en,
  input  logic [ADDR_W-1:0]                   rd_addr,
  input  logic [3:0]                          status,
  output logic [DATA_W-1:0]                   rd_data,
  output logic [NUM_PHASES-1:0][FIELD_W-1:0]  dly,
  output logic                                req_valid,
  output logic                                req_logic
);

  localparam int PACK_W = NUM_PHASES * FIELD_W;

  logic [DATA_W-1:0] mode_q;
  logic [DATA_W-1:0] dly_q;

  // only the two known encodings form a request
  always_comb begin
    req_valid = wr_en && (wr_addr == ADDR_W'(ADR_MODE)) &&
                ((wr_data == MODE_MEM) || (wr_data == MODE_LOGIC));
    req_logic = (wr_data == MODE_LOGIC);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_LOGIC;
      dly_q  <= DLY_RST;
    end else begin
      if (req_valid) mode_q <= wr_data;
      if (wr_en && (wr_addr == ADDR_W'(ADR_DELAY))) dly_q <= wr_data;
    end
  end

  for (genvar g = 0; g < NUM_PHASES; g++) begin : g_field
    assign dly[g] = dly_q[g*FIELD_W +: FIELD_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      case (rd_addr)
        ADDR_W'(ADR_MODE):   rd_data <= mode_q;
        ADDR_W'(ADR_STATUS): rd_data <= {{(DATA_W-4){1'b0}}, status};
        ADDR_W'(ADR_DELAY):  rd_data <= dly_q;
        default:             rd_data <= '0;
      endcase
    end
  end

  if (PACK_W > DATA_W) begin : g_bad_width
    initial $error("delay fields do not fit the data word");
  end

endmodule

// File: rtl/arraymux_fsm.sv
module arraymux_fsm
  import arraymux_pkg::*;
#(
  parameter int FIELD_W = 8
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               req_valid,
  input  logic                               req_logic,
  input  logic [NUM_PHASES-1:0][FIELD_W-1:0] dly,
  output logic                               hs_logic_en,
  output logic                               hs_mem_en,
  output logic                               clk_halt,
  output logic [3:0]                         status
);

  seq_state_t         state_q;
  logic [FIELD_W-1:0] cnt_q;
  logic               rail_q;        // 1: logic rail selected
  logic               tgt_q;
  logic               pend_q;
  logic               pend_logic_q;
  logic               start_req;
  logic               start_tgt;
  logic               start_go;

  function automatic logic [3:0] done_code(input logic on_logic);
    return on_logic ? STS_LOGIC_DONE : STS_MEM_DONE;
  endfunction

  // a fresh write outranks a held one
  always_comb begin
    if (req_valid) begin
      start_req = 1'b1;
      start_tgt = req_logic;
    end else begin
      start_req = pend_q;
      start_tgt = pend_logic_q;
    end
    start_go = (state_q == ST_IDLE) && start_req && (start_tgt != rail_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      cnt_q        <= '0;
      rail_q       <= 1'b1;
      tgt_q        <= 1'b1;
      pend_q       <= 1'b0;
      pend_logic_q <= 1'b0;
      hs_logic_en  <= 1'b1;
      hs_mem_en    <= 1'b0;
      clk_halt     <= 1'b0;
      status       <= STS_LOGIC_DONE;
    end else if (state_q == ST_IDLE) begin
      pend_q <= 1'b0;
      if (start_go) begin
        state_q  <= ST_HALT;
        cnt_q    <= dly[PH_HALT];
        clk_halt <= 1'b1;
        status   <= STS_HALTING;
        tgt_q    <= start_tgt;
      end
    end else begin
      if (req_valid) begin
        pend_q       <= 1'b1;
        pend_logic_q <= req_logic;
      end
      if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end else begin
        case (state_q)
          ST_HALT: begin
            state_q <= ST_POST;
            cnt_q   <= dly[PH_POST];
            status  <= STS_POSTHALT;
          end
          ST_POST: begin
            state_q     <= ST_SEL;
            cnt_q       <= dly[PH_SEL];
            hs_logic_en <= 1'b0;
            hs_mem_en   <= 1'b0;
            status      <= STS_OPEN;
          end
          ST_SEL: begin
            state_q     <= ST_RES;
            cnt_q       <= dly[PH_RES];
            hs_logic_en <= tgt_q;
            hs_mem_en   <= !tgt_q;
            rail_q      <= tgt_q;
            status      <= STS_RESUME;
          end
          default: begin
            state_q  <= ST_IDLE;
            clk_halt <= 1'b0;
            status   <= done_code(tgt_q);
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/arraymux_seq.sv
module arraymux_seq
  import arraymux_pkg::*;
#(
  parameter int                DATA_W     = 32,
  parameter int                ADDR_W     = 2,
  parameter int                FIELD_W    = 8,
  parameter logic [DATA_W-1:0] MODE_MEM   = 'h00,
  parameter logic [DATA_W-1:0] MODE_LOGIC = 'h02,
  parameter logic [DATA_W-1:0] DLY_RST    = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              hs_logic_en,
  output logic              hs_mem_en,
  output logic              clk_halt
);

  logic [NUM_PHASES-1:0][FIELD_W-1:0] dly_w;
  logic                               req_valid_w;
  logic                               req_logic_w;
  logic [3:0]                         status_w;

  arraymux_regs #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .FIELD_W   (FIELD_W),
    .MODE_MEM  (MODE_MEM),
    .MODE_LOGIC(MODE_LOGIC),
    .DLY_RST   (DLY_RST)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .status   (status_w),
    .rd_data  (rd_data),
    .dly      (dly_w),
    .req_valid(req_valid_w),
    .req_logic(req_logic_w)
  );

  arraymux_fsm #(
    .FIELD_W(FIELD_W)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid_w),
    .req_logic  (req_logic_w),
    .dly        (dly_w),
    .hs_logic_en(hs_logic_en),
    .hs_mem_en  (hs_mem_en),
    .clk_halt   (clk_halt),
    .status     (status_w)
  );

endmodule

// File: rtl/arraymux_chk.sv
module arraymux_chk (
  input logic       clk,
  input logic       rst,
  input logic       hs_logic_en,
  input logic       hs_mem_en,
  input logic       clk_halt,
  input logic [3:0] status
);

  // R9: enables never overlap
  a_r9_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(hs_logic_en && hs_mem_en));

  // R9: exactly one rail tied while the clock runs
  a_r9_one_rail_running: assert property (@(posedge clk) disable iff (rst)
    !clk_halt |-> (hs_logic_en ^ hs_mem_en));

  // R10: an enable moves only inside a held halt
  a_r10_logic_en_halted: assert property (@(posedge clk) disable iff (rst)
    (hs_logic_en != $past(hs_logic_en)) |-> (clk_halt && $past(clk_halt)));

  a_r10_mem_en_halted: assert property (@(posedge clk) disable iff (rst)
    (hs_mem_en != $past(hs_mem_en)) |-> (clk_halt && $past(clk_halt)));

  // R3: done codes exactly when running, matching the tied rail
  a_r3_done_when_running: assert property (@(posedge clk) disable iff (rst)
    !clk_halt |-> ((status == 4'h3 && hs_logic_en) || (status == 4'h0 && hs_mem_en)));

  // R4: transitional codes only while halted
  a_r4_busy_codes: assert property (@(posedge clk) disable iff (rst)
    clk_halt |-> (status == 4'h1 || status == 4'h2 || status == 4'h4 || status == 4'h5));

  // R4: a switch opens with the halt-settle code
  a_r4_first_phase: assert property (@(posedge clk) disable iff (rst)
    $rose(clk_halt) |-> (status == 4'h1));

endmodule

bind arraymux_seq arraymux_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .hs_logic_en(hs_logic_en),
  .hs_mem_en  (hs_mem_en),
  .clk_halt   (clk_halt),
  .status     (status_w)
);

// File: tb/arraymux_seq_tb.sv
module arraymux_seq_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        hs_logic_en, hs_mem_en, clk_halt;

  int tests = 0;
  int fails = 0;
  logic cur_logic = 1'b1;

  always #2.5 clk = ~clk;

  arraymux_seq u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .hs_logic_en(hs_logic_en), .hs_mem_en(hs_mem_en), .clk_halt(clk_halt)
  );

  task automatic check(input string req, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a[1:0]; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a[1:0];
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  function automatic logic [31:0] mode_val(input logic on_logic);
    return on_logic ? 32'h02 : 32'h00;
  endfunction

  // full switch with status polling; h/p/s/r are field values
  task automatic run_switch(input int h, input int p, input int s, input int r);
    logic tgt;
    int n_old, n_none, n_new, codes, extra, prev;
    logic seen;
    tgt = !cur_logic;
    wr(2, {p[7:0], h[7:0], r[7:0], s[7:0]});
    rd_en = 1'b1; rd_addr = 2'd1;
    wr(0, mode_val(tgt));
    n_old = 0; n_none = 0; n_new = 0; codes = 0; extra = 0; seen = 1'b0;
    prev = cur_logic ? 3 : 0;
    for (int guard = 0; guard < 3000; guard++) begin
      if (int'(rd_data[3:0]) != prev) begin
        prev = int'(rd_data[3:0]);
        codes = codes * 16 + prev;
      end
      if (clk_halt) begin
        seen = 1'b1;
        if ((tgt ? hs_mem_en : hs_logic_en)) n_old++;
        else if ((tgt ? hs_logic_en : hs_mem_en)) n_new++;
        else n_none++;
      end else if (seen) begin
        if (extra == 2) break;
        extra++;
      end
      @(negedge clk);
    end
    rd_en = 1'b0;
    cur_logic = tgt;
    // R4 R5: old rail held through halt and post-halt phases
    check("R5 old-rail cycles", n_old, h + p + 2);
    check("R5 open gap cycles", n_none, s + 1);
    check("R5 new-rail halted cycles", n_new, r + 1);
    // R4 R3: code order 1,2,4,5 then done code
    check("R4 status order", codes, 32'h12450 + (tgt ? 3 : 0));
  endtask

  task automatic halt_runs(input int ncyc, output int runs[8], output int nruns);
    logic prev;
    prev = 1'b0; nruns = 1;
    for (int k = 0; k < 8; k++) runs[k] = 0;
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk);
      if (clk_halt != prev && nruns < 8) nruns++;
      prev = clk_halt;
      runs[nruns-1]++;
    end
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int runs[8];
    int nruns;
    int vals[3] = '{0, 1, 3};
    int halt_seen;

    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    check("R1 hs_logic_en", hs_logic_en, 1);
    check("R1 hs_mem_en", hs_mem_en, 0);
    check("R1 clk_halt", clk_halt, 0);
    rd(1, d); check("R1 R3 status", d, 32'h3);
    rd(0, d); check("R1 mode", d, 32'h02);
    rd(2, d); check("R1 delay", d, 32'h0);
    rd(3, d); check("R1 unused addr", d, 32'h0);

    // R6 readback
    wr(2, 32'hA1B2C3D4);
    rd(2, d); check("R6 delay readback", d, 32'hA1B2C3D4);

    // R2 ignored encoding: 0x10 and 0x01 start nothing
    wr(0, 32'h10);
    wr(0, 32'h01);
    halt_seen = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (clk_halt) halt_seen++; end
    check("R2 unknown value no halt", halt_seen, 0);
    rd(0, d); check("R2 mode unchanged", d, 32'h02);
    check("R2 still logic rail", hs_logic_en, 1);

    // R7 same-rail write
    wr(0, 32'h02);
    halt_seen = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (clk_halt) halt_seen++; end
    check("R7 same rail no halt", halt_seen, 0);
    rd(1, d); check("R7 status unchanged", d, 32'h3);

    // R6 field positions: halt=1 post=2 sel=3 resume=4
    run_switch(1, 2, 3, 4);
    rd(1, d); check("R3 mem done code", d, 32'h0);
    check("R2 mem rail tied", hs_mem_en, 1);
    run_switch(4, 3, 2, 1);
    rd(1, d); check("R3 logic done code", d, 32'h3);
    check("R2 logic rail tied", hs_logic_en, 1);

    // R5 sweep over small field values, alternating direction
    foreach (vals[a]) foreach (vals[b]) foreach (vals[c]) foreach (vals[e])
      run_switch(vals[a], vals[b], vals[c], vals[e]);

    // R8 held request: each phase 3 cycles, 12 per switch
    wr(2, 32'h02020202);
    d = mode_val(cur_logic);
    fork
      halt_runs(60, runs, nruns);
      begin
        wr(0, mode_val(!cur_logic));
        repeat (3) @(negedge clk);
        wr(0, d);
      end
    join
    check("R8 first switch length", runs[1], 12);
    check("R8 one-cycle gap", runs[2], 1);
    check("R8 held switch length", runs[3], 12);
    check("R8 rail restored", hs_logic_en, cur_logic);

    // R8 latest held request wins; it names the rail just reached
    fork
      halt_runs(60, runs, nruns);
      begin
        wr(0, mode_val(!cur_logic));
        repeat (2) @(negedge clk);
        wr(0, d);
        wr(0, mode_val(!cur_logic));
      end
    join
    cur_logic = !cur_logic;
    check("R8 latest wins single switch", nruns, 3);
    check("R8 switch length", runs[1], 12);
    check("R8 final rail", hs_logic_en, cur_logic);

    // R11 worst case duration
    wr(2, 32'hFFFFFFFF);
    fork
      halt_runs(1100, runs, nruns);
      wr(0, mode_val(!cur_logic));
    join
    cur_logic = !cur_logic;
    check("R11 max halt cycles", runs[1], 1024);
    check("R11 within 10us at 5ns", (runs[1] <= 2000) ? 1 : 0, 1);
    check("R9 one rail after max switch", hs_logic_en ^ hs_mem_en, 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule